// File: doc/BRIEF.md
# Fused Multiply-Add Invalid-Operation Detector

This block sits beside the datapath of a double-precision fused multiply-add unit computing a*c + b or a*c - b, with optional negation of the fused result. It looks only at the three operand encodings and the two operation selects. It returns the invalid-operation status bits for the operation and a control that tells the result path whether it may negate the fused value. It is purely combinational. The surrounding logic ORs its bits into a sticky status register.

The infinity-minus-infinity case is decided from the operand classes and sign bits alone. The block never looks at a rounded product, so an overflowing finite product cannot fake an infinity and a wrong product sign cannot hide one. A fused result that will be a NaN is never negated: the block predicts NaN results from the operands and clears the negate control for them.

Top module: `fma_invalid_detect`

## Requirements
- R1: `snan_flag` is 1 when any of `op_a`, `op_c`, `op_b` is a signaling NaN. A signaling NaN has exponent bits [62:52] all ones, a nonzero fraction [51:0] and fraction bit 51 clear.
- R2: A quiet NaN operand (exponent all ones, fraction bit 51 set) does not set `snan_flag`.
- R3: The product counts as infinite only when at least one multiplicand is infinite (exponent all ones, fraction zero), neither multiplicand is zero (exponent and fraction zero, either sign) and neither is a NaN. An infinity times zero therefore never sets `isi_flag`.
- R4: With `sub_sel`=0, `isi_flag` is 1 exactly when the product is infinite, `op_b` is infinite, and the product sign (XOR of the sign bits [63] of `op_a` and `op_c`) differs from the sign of `op_b`.
- R5: With `sub_sel`=1, `isi_flag` is 1 exactly when the product is infinite, `op_b` is infinite, and the product sign equals the sign of `op_b`.
- R6: A finite or NaN addend never sets `isi_flag`, whatever the multiplicands are.
- R7: `any_exc` is the OR of `snan_flag` and `isi_flag`.
- R8: `neg_en` is 1 when `neg_sel`=1 and the fused result will not be a NaN. The result will be a NaN when any operand is a NaN, when the product is an infinity times a zero, or when `isi_flag` is 1.
- R9: With `neg_sel`=0, `neg_en` is 0. `neg_sel` has no effect on `snan_flag`, `isi_flag` or `any_exc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | First multiplicand |
| op_c | input | 64 | Second multiplicand |
| op_b | input | 64 | Addend |
| sub_sel | input | 1 | 1 selects a*c - b, 0 selects a*c + b |
| neg_sel | input | 1 | 1 requests negation of the fused result |
| snan_flag | output | 1 | Signaling NaN operand seen |
| isi_flag | output | 1 | Infinity minus infinity in the add step |
| any_exc | output | 1 | Any invalid-operation bit set |
| neg_en | output | 1 | Result path may negate the fused result |

## Verification
The hardest case to reach is an infinite addend meeting a product that is infinite only under the exact class rule. Both multiplicands must be non-zero and non-NaN, at least one must be infinite, and the signs must line up for the selected mode. Random 64-bit words almost never land on these encodings. The stimulus therefore draws each operand from a class menu (zero, infinity, quiet NaN, signaling NaN, finite) with a random sign and random payload, so that infinity-times-zero, NaN-times-infinity and both sign parities of the infinite sum occur often in both modes. Directed cases pin the boundary between quiet and signaling NaNs through the fraction top bit.

// File: rtl/fma_chk_pkg.sv
package fma_chk_pkg;

    // Class summary of one floating-point operand.
    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_inf;
        logic is_nan;
        logic is_snan;
    } fp_class_t;

    // Exact-product properties derived from the multiplicand classes.
    typedef struct packed {
        logic inf;       // exact product is an infinity
        logic neg;       // exact product sign
        logic invalid;   // infinity times zero
        logic any_nan;   // a multiplicand is a NaN
    } prod_info_t;

    // Outputs of the top, gathered for the two-process layout.
    typedef struct packed {
        logic snan;
        logic isi;
        logic any_exc;
        logic neg_en;
    } det_out_t;

endpackage

// File: rtl/fma_operand_class.sv
module fma_operand_class
    import fma_chk_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic [OP_W-1:0] opnd,
    output fp_class_t       cls_o
);

    fp_class_t         cls_d;
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              exp_zero;
    logic              frac_nz;

    always_comb begin
        exp_f    = opnd[OP_W-2 -: EXP_W];
        frac_f   = opnd[FRAC_W-1:0];
        exp_ones = &exp_f;
        exp_zero = ~|exp_f;
        frac_nz  = |frac_f;

        cls_d         = '0;
        cls_d.sign    = opnd[OP_W-1];
        cls_d.is_zero = exp_zero & ~frac_nz;
        cls_d.is_inf  = exp_ones & ~frac_nz;
        cls_d.is_nan  = exp_ones & frac_nz;
        cls_d.is_snan = exp_ones & frac_nz & ~frac_f[FRAC_W-1];

        // R1
        snan_subset_chk: assert (!cls_d.is_snan || cls_d.is_nan);
        // R2
        qnan_not_snan_chk: assert (!(cls_d.is_nan && frac_f[FRAC_W-1]) || !cls_d.is_snan);
        // R3
        class_excl_chk: assert ($onehot0({cls_d.is_zero, cls_d.is_inf, cls_d.is_nan}));
    end

    assign cls_o = cls_d;

endmodule

// File: rtl/fma_product_info.sv
module fma_product_info
    import fma_chk_pkg::*;
(
    input  fp_class_t  mul_x,
    input  fp_class_t  mul_y,
    output prod_info_t prod_o
);

    prod_info_t prod_d;

    always_comb begin
        prod_d         = '0;
        prod_d.any_nan = mul_x.is_nan | mul_y.is_nan;
        prod_d.inf     = (mul_x.is_inf | mul_y.is_inf)
                       & ~mul_x.is_zero & ~mul_y.is_zero
                       & ~prod_d.any_nan;
        prod_d.neg     = mul_x.sign ^ mul_y.sign;
        prod_d.invalid = (mul_x.is_inf & mul_y.is_zero)
                       | (mul_x.is_zero & mul_y.is_inf);

        // R3
        prod_inf_src_chk: assert (!prod_d.inf || mul_x.is_inf || mul_y.is_inf);
        // R3
        prod_zero_block_chk: assert (!(mul_x.is_zero || mul_y.is_zero) || !prod_d.inf);
        // R3
        prod_excl_chk: assert ($onehot0({prod_d.inf, prod_d.invalid}));
    end

    assign prod_o = prod_d;

endmodule

// File: rtl/fma_sum_check.sv
module fma_sum_check
    import fma_chk_pkg::*;
(
    input  prod_info_t prod_i,
    input  fp_class_t  addend_i,
    input  logic       sub_sel,
    output logic       isi_o
);

    logic eff_addend_neg;
    logic isi_d;

    always_comb begin
        // subtract flips the addend sign seen by the adder
        eff_addend_neg = addend_i.sign ^ sub_sel;
        isi_d          = prod_i.inf & addend_i.is_inf & (prod_i.neg ^ eff_addend_neg);

        // R6
        isi_addend_chk: assert (!isi_d || addend_i.is_inf);
        // R3
        isi_prod_chk: assert (!isi_d || (prod_i.inf && !prod_i.invalid));
        // R4
        isi_add_sign_chk: assert (!(isi_d && !sub_sel) || (prod_i.neg != addend_i.sign));
        // R5
        isi_sub_sign_chk: assert (!(isi_d && sub_sel) || (prod_i.neg == addend_i.sign));
    end

    assign isi_o = isi_d;

endmodule

// File: rtl/fma_invalid_detect.sv
module fma_invalid_detect
    import fma_chk_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_c,
    input  logic [OP_W-1:0] op_b,
    input  logic            sub_sel,
    input  logic            neg_sel,
    output logic            snan_flag,
    output logic            isi_flag,
    output logic            any_exc,
    output logic            neg_en
);

    localparam int N_OPS = 3;
    localparam int IDX_A = 0;
    localparam int IDX_C = 1;
    localparam int IDX_B = 2;

    logic [OP_W-1:0] opnds [N_OPS];
    fp_class_t       cls   [N_OPS];
    prod_info_t      prod;
    logic            isi;
    det_out_t        out_d;
    logic            nan_result;
    logic [N_OPS-1:0] snan_vec;
    logic [N_OPS-1:0] nan_vec;

    assign opnds[IDX_A] = op_a;
    assign opnds[IDX_C] = op_c;
    assign opnds[IDX_B] = op_b;

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
        fma_operand_class #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) cls_i (
            .opnd  (opnds[gi]),
            .cls_o (cls[gi])
        );
        assign snan_vec[gi] = cls[gi].is_snan;
        assign nan_vec[gi]  = cls[gi].is_nan;
    end

    fma_product_info prod_i (
        .mul_x  (cls[IDX_A]),
        .mul_y  (cls[IDX_C]),
        .prod_o (prod)
    );

    fma_sum_check sum_i (
        .prod_i   (prod),
        .addend_i (cls[IDX_B]),
        .sub_sel  (sub_sel),
        .isi_o    (isi)
    );

    always_comb begin
        nan_result    = (|nan_vec) | prod.invalid | isi;
        out_d         = '0;
        out_d.snan    = |snan_vec;
        out_d.isi     = isi;
        out_d.any_exc = out_d.snan | out_d.isi;
        out_d.neg_en  = neg_sel & ~nan_result;

        // R8
        neg_nan_chk: assert (!out_d.neg_en || !(|nan_vec));
        // R9
        neg_sel_chk: assert (neg_sel || !out_d.neg_en);
        // R7
        exc_cover_chk: assert (!out_d.snan || out_d.any_exc);
        // R1
        snan_nan_chk: assert (!out_d.snan || (|nan_vec));
    end

    assign snan_flag = out_d.snan;
    assign isi_flag  = out_d.isi;
    assign any_exc   = out_d.any_exc;
    assign neg_en    = out_d.neg_en;

endmodule

// File: tb/fma_invalid_detect_tb.sv
module fma_invalid_detect_tb_top;

    logic        clk = 1'b0;
    logic [63:0] op_a, op_c, op_b;
    logic        sub_sel, neg_sel;
    logic        snan_flag, isi_flag, any_exc, neg_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    fma_invalid_detect dut_i (
        .op_a      (op_a),
        .op_c      (op_c),
        .op_b      (op_b),
        .sub_sel   (sub_sel),
        .neg_sel   (neg_sel),
        .snan_flag (snan_flag),
        .isi_flag  (isi_flag),
        .any_exc   (any_exc),
        .neg_en    (neg_en)
    );

    localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SNAN   = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] ONE    = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] N_TWO  = 64'hC000_0000_0000_0000;
    localparam logic [63:0] BIG    = 64'h7FEF_FFFF_FFFF_FFFF;

    function automatic bit f_inf(logic [63:0] v);
        return v[62:52] == 11'h7FF && v[51:0] == 52'd0;
    endfunction
    function automatic bit f_nan(logic [63:0] v);
        return v[62:52] == 11'h7FF && v[51:0] != 52'd0;
    endfunction
    function automatic bit f_snan(logic [63:0] v);
        return f_nan(v) && !v[51];
    endfunction
    function automatic bit f_zero(logic [63:0] v);
        return v[62:0] == 63'd0;
    endfunction

    function automatic bit exp_isi(logic [63:0] a, logic [63:0] c, logic [63:0] b, bit sub);
        bit pinf, pneg;
        pinf = (f_inf(a) || f_inf(c)) && !f_zero(a) && !f_zero(c) && !f_nan(a) && !f_nan(c);
        pneg = a[63] != c[63];
        if (!(pinf && f_inf(b))) return 1'b0;
        return sub ? (pneg == b[63]) : (pneg != b[63]);
    endfunction

    function automatic bit exp_neg(logic [63:0] a, logic [63:0] c, logic [63:0] b, bit sub, bit ng);
        bit nanres;
        nanres = f_nan(a) || f_nan(b) || f_nan(c)
              || (f_inf(a) && f_zero(c)) || (f_zero(a) && f_inf(c))
              || exp_isi(a, c, b, sub);
        return ng && !nanres;
    endfunction

    function automatic logic [63:0] rand_op();
        logic [63:0] v;
        int k;
        k = int'($urandom_range(0, 5));
        v = {$urandom(), $urandom()};
        case (k)
            0: v[62:0] = 63'd0;
            1: v[62:0] = P_INF[62:0];
            2: begin v[62:51] = 12'hFFF; end
            3: begin v[62:51] = 12'hFFE; if (v[50:0] == 51'd0) v[0] = 1'b1; end
            default: if (v[62:52] == 11'h7FF) v[62] = 1'b0;
        endcase
        return v;
    endfunction

    task automatic chk(string tag, string name, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b a=%h c=%h b=%h sub=%0b neg=%0b",
                     tag, name, act, exp, op_a, op_c, op_b, sub_sel, neg_sel);
        end
    endtask

    task automatic apply(logic [63:0] a, logic [63:0] c, logic [63:0] b, bit sub, bit ng, string tag);
        bit e_snan, e_isi;
        @(posedge clk);
        op_a = a; op_c = c; op_b = b; sub_sel = sub; neg_sel = ng;
        @(negedge clk);
        e_snan = f_snan(a) || f_snan(c) || f_snan(b);
        e_isi  = exp_isi(a, c, b, sub);
        chk(tag, "snan_flag", snan_flag, e_snan);
        chk(tag, "isi_flag", isi_flag, e_isi);
        chk({tag, "/R7"}, "any_exc", any_exc, e_snan | e_isi);
        chk({tag, "/R8"}, "neg_en", neg_en, exp_neg(a, c, b, sub, ng));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        op_a = ONE; op_c = ONE; op_b = ONE; sub_sel = 1'b0; neg_sel = 1'b0;
        @(negedge clk);
        // reset/idle state with plain finite operands
        chk("R9", "neg_en idle", neg_en, 1'b0);
        chk("R7", "any_exc idle", any_exc, 1'b0);

        // R1: signaling NaN in each position
        apply(SNAN, ONE, ONE, 1'b0, 1'b1, "R1");
        apply(ONE, SNAN, ONE, 1'b0, 1'b0, "R1");
        apply(ONE, ONE, SNAN | 64'h8000_0000_0000_0000, 1'b1, 1'b1, "R1");
        // R2: quiet NaN and the fraction-top-bit boundary
        apply(QNAN, ONE, ONE, 1'b0, 1'b1, "R2");
        apply(ONE, ONE, 64'h7FF8_0000_0000_0001, 1'b0, 1'b1, "R2");
        apply(ONE, 64'h7FF7_FFFF_FFFF_FFFF, ONE, 1'b0, 1'b1, "R2");
        // R3: inf*0, NaN*inf, overflowing finite product
        apply(P_INF, N_ZERO, N_INF, 1'b0, 1'b1, "R3");
        apply(P_ZERO, N_INF, P_INF, 1'b1, 1'b1, "R3");
        apply(QNAN, P_INF, N_INF, 1'b0, 1'b1, "R3");
        apply(BIG, BIG, N_INF, 1'b0, 1'b1, "R3");
        // R4: add mode
        apply(P_INF, ONE, N_INF, 1'b0, 1'b1, "R4");
        apply(P_INF, N_TWO, N_INF, 1'b0, 1'b1, "R4");
        apply(N_INF, N_INF, N_INF, 1'b0, 1'b1, "R4");
        // R5: subtract mode
        apply(P_INF, ONE, P_INF, 1'b1, 1'b1, "R5");
        apply(P_INF, N_TWO, P_INF, 1'b1, 1'b1, "R5");
        apply(ONE, N_INF, N_INF, 1'b1, 1'b0, "R5");
        // R6: finite or NaN addend
        apply(P_INF, ONE, ONE, 1'b0, 1'b1, "R6");
        apply(P_INF, ONE, QNAN, 1'b1, 1'b1, "R6");
        // R9: neg_sel low, and neg_sel no effect on flags
        apply(ONE, N_TWO, ONE, 1'b0, 1'b0, "R9");
        apply(P_INF, ONE, N_INF, 1'b0, 1'b0, "R9");

        for (int i = 0; i < 4000; i++) begin
            apply(rand_op(), rand_op(), rand_op(), 1'($urandom()), 1'($urandom()), "R1R9rand");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule